// File: doc/BRIEF.md
# BIST Failure Diagnosis Controller with Rewind

This block sits beside a memory self-test engine during a diagnostic run. Each time the engine flags a miscompare, the controller decides whether that failure is new. A new failure stalls the engine, and its record is captured. The record holds the address, the March element, the operation within the element and the failing data bits. It is shifted serially to the tester on the tester's own slow clock.

Once the tester side confirms the unload through a four-phase request/acknowledge exchange, the controller does not let the engine carry on from the stall point. It asks the engine to restart at the first address of the element that was running when the failure appeared. On that rerun it discards as many fail strobes as failures from that element have already been sent out. Every cell therefore sees the full sequence of operations back-to-back at speed, and no failure is reported twice. When the engine finishes its last element with no new failure pending, the controller flags completion and presents the number of failures reported.

Top module: `bist_diag_rewind`

## Requirements
- R1: After reset, halt, restart, diag_done and so_valid are low, and fail_total is zero.
- R2: A new failure sets halt from the next clk edge. Halt stays high until the serial unload and the handshake back to the clk domain have both completed.
- R3: A record is 29 bits, sent most significant bit first: address[15:0], then element[2:0], then operation[1:0], then failing bits[7:0]. so_data changes after a rising tck edge, and so_valid stays high for exactly 29 consecutive tck cycles.
- R4: restart is a single-cycle pulse. It is issued only after the tester side has dropped its acknowledge. While it is high, halt is low and restart_elem equals the element of the failure just unloaded.
- R5: After a restart, the first N fail strobes are ignored, where N is the number of failures already reported from the restarted element. They cause no halt and no record.
- R6: Fail strobes that arrive while halt is high are ignored. A failure first seen in that window is reported on the rerun.
- R7: A run_done pulse while running sets diag_done, which then stays high with halt low. fail_total equals the number of records sent.
- R8: Every distinct failure is reported exactly once, in the order the engine first meets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast test clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fail_vld | input | 1 | Miscompare strobe from the engine |
| fail_addr | input | 16 | Failing address |
| fail_elem | input | 3 | March element active at the failure |
| fail_op | input | 2 | Operation index within the element |
| fail_bits | input | 8 | Failing data bits |
| run_done | input | 1 | Engine finished its final element |
| halt | output | 1 | Stall request to the engine |
| restart | output | 1 | One-cycle rewind command |
| restart_elem | output | 3 | Element to restart from, at its first address |
| diag_done | output | 1 | Diagnostic run complete |
| fail_total | output | 8 | Count of failures reported |
| tck | input | 1 | Slow tester clock |
| so_data | output | 1 | Serial record bit |
| so_valid | output | 1 | Serial bit qualifier |
| tst_halt | output | 1 | Halt status synchronized to tck |

## Verification
If the skip count were wrong, the symptom would appear on the first rerun. A duplicate record would appear, or a later failure would be missing, and this would show within one unload of the faulty restart. If the stored element were wrong, restart_elem would be wrong on the very next restart pulse. If the handshake order were broken, a restart would come while so_valid is still high, or a record would come out truncated. The bench places two failures in adjacent addresses so that the second one arrives while halt is high. This is the case that exposes any leakage of strobes during a stall.

// File: rtl/bist_diag_rewind.sv
module bist_diag_rewind #(
  parameter int AW = 16,
  parameter int EW = 3,
  parameter int OW = 2,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail_vld,
  input  logic [AW-1:0] fail_addr,
  input  logic [EW-1:0] fail_elem,
  input  logic [OW-1:0] fail_op,
  input  logic [DW-1:0] fail_bits,
  input  logic          run_done,
  output logic          halt,
  output logic          restart,
  output logic [EW-1:0] restart_elem,
  output logic          diag_done,
  output logic [CW-1:0] fail_total,
  input  logic          tck,
  output logic          so_data,
  output logic          so_valid,
  output logic          tst_halt
);
  localparam int RW = AW + EW + OW + DW;
  localparam int BW = $clog2(RW);

  typedef enum logic [1:0] {S_RUN, S_ACK, S_REL, S_DONE} st_t;
  st_t st;

  logic [RW-1:0] rec;
  logic          req;
  logic [CW-1:0] in_elem, skip_left;
  logic [EW-1:0] last_elem;
  logic          a1, ack_s;

  assign halt      = (st == S_ACK) || (st == S_REL);
  assign diag_done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_RUN; rec <= '0; req <= 1'b0; fail_total <= '0;
      in_elem <= '0; skip_left <= '0; last_elem <= '0;
      restart <= 1'b0; restart_elem <= '0;
    end else begin
      restart <= 1'b0;
      case (st)
        S_RUN:
          if (fail_vld && !restart) begin
            if (skip_left != '0) skip_left <= skip_left - 1'b1;
            else begin
              rec          <= {fail_addr, fail_elem, fail_op, fail_bits};
              req          <= 1'b1;
              fail_total   <= fail_total + 1'b1;
              in_elem      <= (fail_elem == last_elem) ? in_elem + 1'b1 : CW'(1);
              last_elem    <= fail_elem;
              restart_elem <= fail_elem;
              st           <= S_ACK;
            end
          end else if (run_done && !restart) st <= S_DONE;
        S_ACK:
          if (ack_s) begin req <= 1'b0; st <= S_REL; end
        S_REL:
          if (!ack_s) begin restart <= 1'b1; skip_left <= in_elem; st <= S_RUN; end
        default: ;
      endcase
    end

  logic          ack, rq1, rq2, h1;
  logic          busy;
  logic [RW-1:0] sh;
  logic [BW-1:0] cnt;

  assign so_data  = sh[RW-1];
  assign so_valid = busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {a1, ack_s} <= '0;
    else        {a1, ack_s} <= {ack, a1};

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      rq1 <= 1'b0; rq2 <= 1'b0; h1 <= 1'b0; tst_halt <= 1'b0;
      busy <= 1'b0; ack <= 1'b0; sh <= '0; cnt <= '0;
    end else begin
      {rq1, rq2}     <= {req, rq1};
      {h1, tst_halt} <= {halt, h1};
      if (busy) begin
        sh <= sh << 1;
        if (cnt == '0) begin busy <= 1'b0; ack <= 1'b1; end
        else cnt <= cnt - 1'b1;
      end else if (ack) begin
        if (!rq2) ack <= 1'b0;
      end else if (rq2) begin
        sh <= rec; busy <= 1'b1; cnt <= BW'(RW - 1);
      end
    end

  a_r2_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(fail_vld));
  a_r4_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
  a_r4_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!ack_s && !req && !halt));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    diag_done |=> (diag_done && !halt));
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack_s) |=> req);
  a_r3_valid_req: assert property (@(posedge tck) disable iff (!rst_n)
    so_valid |-> rq2);
endmodule

// File: tb/bist_diag_rewind_tb.sv
module bist_diag_rewind_tb;
  logic clk = 0, tck = 0, rst_n = 0;
  always #2  clk = ~clk;
  always #20 tck = ~tck;

  logic fail_vld, run_done, halt, restart, diag_done, so_data, so_valid, tst_halt;
  logic [15:0] fail_addr; logic [2:0] fail_elem, restart_elem;
  logic [1:0] fail_op; logic [7:0] fail_bits, fail_total;

  bist_diag_rewind u_dut (.clk, .rst_n, .fail_vld, .fail_addr, .fail_elem, .fail_op,
    .fail_bits, .run_done, .halt, .restart, .restart_elem, .diag_done, .fail_total,
    .tck, .so_data, .so_valid, .tst_halt);

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  logic [2:0] e; logic [3:0] a; logic fin;
  function automatic bit is_fail(input logic [2:0] ee, input logic [3:0] aa);
    return (ee == 1 && (aa == 3 || aa == 9 || aa == 10)) || (ee == 3 && aa == 5);
  endfunction
  function automatic logic [28:0] mk(input logic [2:0] ee, input logic [3:0] aa);
    return {12'h3C0, aa, ee, aa[1:0], 1'b1, ee, aa};
  endfunction

  assign fail_vld  = is_fail(e, a) && !restart && !fin;
  assign fail_addr = {12'h3C0, a};
  assign fail_elem = e;
  assign fail_op   = a[1:0];
  assign fail_bits = {1'b1, e, a};
  assign run_done  = (e == 3 && a == 15) && !halt && !restart && !fin;

  initial begin
    e = 0; a = 0; fin = 0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin e <= 0; a <= 0; fin <= 0; end
      else if (restart) begin e <= restart_elem; a <= 0; end
      else if (!halt && !fin) begin
        if (a == 15) begin if (e == 3) fin <= 1; else begin e <= e + 1; a <= 0; end end
        else a <= a + 1;
      end
    end
  end

  logic [28:0] rec_q[$];
  logic [2:0]  elem_q[$];
  task automatic expect_fail(input logic [2:0] ee, input logic [3:0] aa);
    rec_q.push_back(mk(ee, aa));
    elem_q.push_back(ee);
  endtask

  initial begin
    logic [28:0] sr;
    forever begin
      @(negedge tck);
      if (so_valid) begin
        chk(halt, "R2 halt held during unload", halt, 1);
        sr = '0;
        for (int i = 0; i < 29; i++) begin
          if (i > 0) @(negedge tck);
          chk(so_valid, "R3 valid length", so_valid, 1);
          sr = {sr[27:0], so_data};
        end
        @(negedge tck);
        chk(!so_valid, "R3 valid drops after 29", so_valid, 0);
        if (rec_q.size() == 0) chk(0, "R8 extra record", sr, 0);
        else begin
          logic [28:0] x;
          x = rec_q.pop_front();
          chk(sr == x, "R3 R5 R6 R8 record", sr, x);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (restart) begin
        chk(!so_valid && !halt, "R4 restart after unload", {so_valid, halt}, 0);
        if (elem_q.size() == 0) chk(0, "R4 extra restart", restart_elem, 0);
        else begin
          logic [2:0] x;
          x = elem_q.pop_front();
          chk(restart_elem == x, "R4 restart element", restart_elem, x);
        end
      end
    end
  end

  initial begin
    expect_fail(1, 3); expect_fail(1, 9); expect_fail(1, 10); expect_fail(3, 5);
    #1;
    chk(!halt, "R1 halt", halt, 0);
    chk(!restart, "R1 restart", restart, 0);
    chk(!diag_done, "R1 diag_done", diag_done, 0);
    chk(!so_valid, "R1 so_valid", so_valid, 0);
    chk(fail_total == 0, "R1 fail_total", fail_total, 0);
    #50 rst_n = 1;
    fork
      begin wait (diag_done); end
      begin #200000; chk(0, "watchdog", 0, 1); end
    join_any
    disable fork;
    repeat (20) @(negedge clk);
    chk(diag_done, "R7 done sticky", diag_done, 1);
    chk(!halt, "R7 halt low at done", halt, 0);
    chk(fail_total == 4, "R7 fail_total", fail_total, 4);
    chk(rec_q.size() == 0, "R8 all records seen", rec_q.size(), 0);
    chk(elem_q.size() == 0, "R5 all restarts seen", elem_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule